// File: doc/BRIEF.md
# Latch-Based Register File

A small multi-ported storage array. It keeps each word in level-sensitive latches and uses no edge-triggered flip-flops for storage. On the rising clock edge, each write port captures its enable, address and data into flops. In the low half of the following cycle, the decoded word's latches open and take the captured value. They close again at the next rising edge. The captured values stay stable for the whole time a latch is open, so the write data cannot race through.

Each read port selects a word combinationally from its own address. A read in a given cycle therefore returns the contents as they stood before any write presented in that same cycle. An optional output latch per read port holds the read value through the high phase of the clock. A parameter adds a second write port. That port puts a data-select mux in front of every word, and port 0 takes priority when both ports address the same word.

Top module: `latch_regfile`

## Requirements
- R1: A write presented with `we_i[p]` high in cycle c is returned by any read port of that address in cycle c+1 and later.
- R2: A write changes only the word it addresses; every other word keeps its value.
- R3: `rdata_o[p]` follows `raddr_i[p]` combinationally within the same cycle, with no clock edge in between.
- R4: A read of a word in the same cycle that word is written returns its previous contents.
- R5: When both write ports address the same word in the same cycle, port 0's data is stored.
- R6: Two write ports addressing different words in one cycle both store their data.
- R7: While `we_i[p]` is low, that port changes no word, whatever its address and data inputs carry.
- R8: While `rst_ni` is low, no word is written, even with write enables asserted. After release, the stored contents are unchanged.
- R9: Read ports are independent, and each returns its own addressed word in the same cycle.
- R10: With `OUT_LATCH` set, `rdata_o[p]` holds through the clock-high phase the value it showed at the end of the preceding low phase, even if `raddr_i[p]` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; storage latches open only while it is low |
| rst_ni | input | 1 | Active-low asynchronous reset of the write capture flops |
| we_i | input | NUM_WR | Write enable per write port |
| waddr_i | input | NUM_WR x AW | Write address per port |
| wdata_i | input | NUM_WR x DW | Write data per port |
| raddr_i | input | NUM_RD x AW | Read address per port |
| rdata_o | output | NUM_RD x DW | Read data per port |

## Verification
The assertions assume that the write inputs settle before the rising edge that captures them. They also assume that nothing but the capture flops drives the word latches, so each word can only change during the low phase that follows a capture. The stimulus changes every input one nanosecond after a rising edge and leaves it still for the rest of the cycle. It samples the combinational read outputs just before the next rising edge, and the latched outputs early in the high phase. Random traffic uses only in-range addresses. The bench writes every word before comparing it, so no unknown storage value enters a check.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  parameter int unsigned LRF_WORDS  = 8;
  parameter int unsigned LRF_WIDTH  = 16;
  parameter int unsigned LRF_NUM_WR = 1;
  parameter int unsigned LRF_NUM_RD = 1;
endpackage

// File: rtl/lrf_wr_capture.sv
module lrf_wr_capture #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  // held for the full cycle, covering the low phase when the word latch is open
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_o   <= we_i;
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/lrf_wr_arbiter.sv
module lrf_wr_arbiter #(
  parameter int unsigned WORDS  = 8,
  parameter int unsigned AW     = 3,
  parameter int unsigned DW     = 16,
  parameter int unsigned NUM_WR = 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_WR-1:0]             we_q_i,
  input  logic [NUM_WR-1:0][AW-1:0]     addr_q_i,
  input  logic [NUM_WR-1:0][DW-1:0]     data_q_i,
  output logic [WORDS-1:0]              word_sel_o,
  output logic [WORDS-1:0][DW-1:0]      word_data_o
);
  // highest port first so port 0 overrides on a shared word
  always_comb begin
    word_sel_o  = '0;
    word_data_o = '0;
    for (int w = 0; w < WORDS; w++) begin
      for (int p = NUM_WR - 1; p >= 0; p--) begin
        if (we_q_i[p] && (addr_q_i[p] == AW'(w))) begin
          word_sel_o[w]  = 1'b1;
          word_data_o[w] = data_q_i[p];
        end
      end
    end
  end

  p_sel_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(word_sel_o) <= $countones(we_q_i));

  p_no_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q_i == '0) |-> (word_sel_o == '0));
endmodule

// File: rtl/lrf_word.sv
module lrf_word #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          sel_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  logic gate;
  assign gate = ~clk_i & sel_i;

  always_latch begin
    if (gate) q_o <= d_i;
  end
endmodule

// File: rtl/lrf_rd_port.sv
module lrf_rd_port #(
  parameter int unsigned WORDS     = 8,
  parameter int unsigned AW        = 3,
  parameter int unsigned DW        = 16,
  parameter bit          OUT_LATCH = 1'b0
) (
  input  logic                     clk_i,
  input  logic [WORDS-1:0][DW-1:0] words_i,
  input  logic [AW-1:0]            raddr_i,
  output logic [DW-1:0]            rdata_o
);
  logic [DW-1:0] rd_sel;

  if (WORDS == (1 << AW)) begin : g_full
    assign rd_sel = words_i[raddr_i];
  end else begin : g_part
    always_comb begin
      rd_sel = '0;
      for (int w = 0; w < WORDS; w++) begin
        if (raddr_i == AW'(w)) rd_sel = words_i[w];
      end
    end
  end

  if (OUT_LATCH) begin : g_olat
    logic [DW-1:0] hold_q;
    // open while low, holds through the high phase
    always_latch begin
      if (!clk_i) hold_q <= rd_sel;
    end
    assign rdata_o = hold_q;
  end else begin : g_comb
    assign rdata_o = rd_sel;
  end
endmodule

// File: rtl/latch_regfile.sv
module latch_regfile #(
  parameter int unsigned WORDS     = lrf_pkg::LRF_WORDS,
  parameter int unsigned DW        = lrf_pkg::LRF_WIDTH,
  parameter int unsigned NUM_WR    = lrf_pkg::LRF_NUM_WR,
  parameter int unsigned NUM_RD    = lrf_pkg::LRF_NUM_RD,
  parameter bit          OUT_LATCH = 1'b0,
  localparam int unsigned AW       = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_WR-1:0]         we_i,
  input  logic [NUM_WR-1:0][AW-1:0] waddr_i,
  input  logic [NUM_WR-1:0][DW-1:0] wdata_i,
  input  logic [NUM_RD-1:0][AW-1:0] raddr_i,
  output logic [NUM_RD-1:0][DW-1:0] rdata_o
);
  logic [NUM_WR-1:0]         we_q;
  logic [NUM_WR-1:0][AW-1:0] waddr_q;
  logic [NUM_WR-1:0][DW-1:0] wdata_q;
  logic [WORDS-1:0]          word_sel;
  logic [WORDS-1:0][DW-1:0]  word_data;
  logic [WORDS-1:0][DW-1:0]  words;

  for (genvar p = 0; p < NUM_WR; p++) begin : g_wr
    lrf_wr_capture #(.AW(AW), .DW(DW)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we_i[p]),
      .addr_i (waddr_i[p]),
      .data_i (wdata_i[p]),
      .we_o   (we_q[p]),
      .addr_o (waddr_q[p]),
      .data_o (wdata_q[p])
    );
  end

  lrf_wr_arbiter #(.WORDS(WORDS), .AW(AW), .DW(DW), .NUM_WR(NUM_WR)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_q_i      (we_q),
    .addr_q_i    (waddr_q),
    .data_q_i    (wdata_q),
    .word_sel_o  (word_sel),
    .word_data_o (word_data)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    lrf_word #(.DW(DW)) u_word (
      .clk_i (clk_i),
      .sel_i (word_sel[w]),
      .d_i   (word_data[w]),
      .q_o   (words[w])
    );
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    lrf_rd_port #(.WORDS(WORDS), .AW(AW), .DW(DW), .OUT_LATCH(OUT_LATCH)) u_rd (
      .clk_i   (clk_i),
      .words_i (words),
      .raddr_i (raddr_i[r]),
      .rdata_o (rdata_o[r])
    );
  end

  // word latched during the low phase must match the captured data at the closing edge
  p_write_lands_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q[0] && (int'(waddr_q[0]) < WORDS)) |-> (words[waddr_q[0]] == wdata_q[0]));

  if (NUM_WR > 1) begin : g_chk2
    p_second_port_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_q[1] && !(we_q[0] && (waddr_q[0] == waddr_q[1])) && (int'(waddr_q[1]) < WORDS))
      |-> (words[waddr_q[1]] == wdata_q[1]));
  end
endmodule

// File: tb/latch_regfile_tb_top.sv
module latch_regfile_tb_top;
  localparam int unsigned WORDS = 8;
  localparam int unsigned DW    = 16;
  localparam int unsigned AW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]         we = '0;
  logic [1:0][AW-1:0] waddr = '0;
  logic [1:0][DW-1:0] wdata = '0;
  logic [1:0][AW-1:0] raddr = '0;
  logic [1:0][DW-1:0] rdata, rdata_lat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] refm [WORDS];
  bit            vld  [WORDS];
  logic [DW-1:0] lat_exp [2];
  bit            lat_ok  [2];

  always #5 clk = ~clk;

  latch_regfile #(.WORDS(WORDS), .DW(DW), .NUM_WR(2), .NUM_RD(2), .OUT_LATCH(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata));

  latch_regfile #(.WORDS(WORDS), .DW(DW), .NUM_WR(2), .NUM_RD(2), .OUT_LATCH(1'b1)) dut_lat_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata_lat));

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // called 1 ns after a rising edge; returns 1 ns after the next one
  task automatic step(string tag, bit w0, int a0, int d0, bit w1, int a1, int d1,
                      int r0, int r1);
    we[0] = w0; waddr[0] = AW'(a0); wdata[0] = DW'(d0);
    we[1] = w1; waddr[1] = AW'(a1); wdata[1] = DW'(d1);
    raddr[0] = AW'(r0); raddr[1] = AW'(r1);
    #2;
    for (int p = 0; p < 2; p++)
      if (lat_ok[p]) chk("R10 output latch hold", rdata_lat[p], lat_exp[p]);
    #6;
    for (int p = 0; p < 2; p++) begin
      if (vld[raddr[p]]) chk(tag, rdata[p], refm[raddr[p]]);
      lat_ok[p]  = vld[raddr[p]];
      lat_exp[p] = refm[raddr[p]];
    end
    @(posedge clk);
    if (rst_n) begin
      if (w1) begin refm[a1] = DW'(d1); vld[a1] = 1'b1; end
      if (w0) begin refm[a0] = DW'(d0); vld[a0] = 1'b1; end
    end
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin vld[i] = 1'b0; refm[i] = '0; end
    lat_ok[0] = 1'b0; lat_ok[1] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: fill every word through port 0
    for (int i = 0; i < WORDS; i++) step("R1 fill", 1, i, 16'h1000 + i, 0, 0, 0, 0, 0);
    for (int i = 0; i < WORDS; i++) step("R1 readback", 0, 0, 0, 0, 0, 0, i, (i + 1) % WORDS);

    // R4: read the word being written in the same cycle
    step("R4 same-cycle read", 1, 2, 16'h1234, 0, 0, 0, 2, 2);
    step("R4 next-cycle read", 0, 0, 0, 0, 0, 0, 2, 2);
    chk("R4 new value visible", rdata[0], 16'h1234);

    // R5: both ports on one word, port 0 wins
    step("R5 conflict", 1, 5, 16'hAAAA, 1, 5, 16'h5555, 0, 1);
    step("R5 readback", 0, 0, 0, 0, 0, 0, 5, 5);
    chk("R5 port0 wins", rdata[0], 16'hAAAA);

    // R6: two ports to different words
    step("R6 dual write", 1, 3, 16'h3333, 1, 6, 16'h6666, 0, 1);
    step("R6 readback", 0, 0, 0, 0, 0, 0, 3, 6);
    chk("R6 port0 word", rdata[0], 16'h3333);
    chk("R6 port1 word", rdata[1], 16'h6666);

    // R2: single write then sweep every word
    step("R2 write", 1, 1, 16'hBEEF, 0, 0, 0, 0, 0);
    for (int i = 0; i < WORDS; i++) step("R2 sweep", 0, 0, 0, 0, 0, 0, i, WORDS - 1 - i);

    // R7: enables low with live address and data
    for (int i = 0; i < 8; i++)
      step("R7 disabled write", 0, i, 16'hDEAD, 0, 7 - i, 16'hF00D, i, 7 - i);
    for (int i = 0; i < WORDS; i++) step("R7 unchanged", 0, 0, 0, 0, 0, 0, i, i);

    // R3 and R9: address changes each cycle, ports differ
    for (int i = 0; i < 16; i++) step("R3 R9 comb read", 0, 0, 0, 0, 0, 0, i % WORDS, (i * 3 + 1) % WORDS);

    // R8: reset with write enables asserted
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) step("R8 in reset", 1, 4, 16'h0BAD, 1, 0, 16'h0BAD, 4, 0);
    rst_n = 1'b1;
    step("R8 after reset", 0, 0, 0, 0, 0, 0, 4, 0);
    chk("R8 word4 kept", rdata[0], 16'h1004);
    chk("R8 word0 kept", rdata[1], 16'h1000);

    // mixed random traffic against the reference
    for (int i = 0; i < 400; i++)
      step("R2 random", 1'($urandom), int'($urandom % WORDS), int'($urandom & 16'hFFFF),
           1'($urandom), int'($urandom % WORDS), int'($urandom & 16'hFFFF),
           int'($urandom % WORDS), int'($urandom % WORDS));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule